// File: doc/BRIEF.md
# Bus Activity Power-Down Controller

This controller decides when a memory-and-logic peripheral on an 8-bit microcontroller bus may go into power-down. It watches the four bus strobes (read, write, program-fetch enable and address latch). When the strobes stay quiet, it counts rising edges of a slow external clock. That clock is expected to stop while the host sleeps. If the count reaches a programmable limit and automatic power-down is enabled, the controller turns off the address/data input buffers and puts the memories in standby. Any strobe transition brings the buffers back on the next cycle.

Firmware has two more paths. It can force power-down directly through a control bit, without using the counter or the slow clock. A separate chip-select park input puts only the memories in standby and leaves the buffers and the logic running. The block also gates each bus strobe away from the programmable-logic inputs under a per-strobe mask. It drives the logic speed and zero-power mode selects, and it reports the power-down cause in a read-only status register.

Top module: `bus_idle_pwr_ctrl`

## Requirements
- R1: After a synchronous active-low reset:
  - buf_en=1, mem_standby=0 (with cs_park=0), turbo_en=1, zero_pwr_en=0 and pd_active=0.
  - The control (address 0), mask (address 1) and status (address 3) registers read 0.
  - The limit register (address 2) reads 8.
- R2: The idle counter behaves as follows.
  - It advances on each rising edge of slow_clk_in seen through a two-flop synchroniser, while control bit 0 (auto enable) is 1 and no strobe changes.
  - Automatic power-down starts one cycle after the count reaches the limit field (address 2, bits 3:0).
  - A limit of 0 never times out.
- R3: A change in either direction on any of bus_rd, bus_wr, bus_psen or bus_ale has three effects, seen on the following cycle: the idle count is cleared, automatic power-down ends, and buf_en is high.
- R4: While power-down is active, buf_en is 0, mem_standby is 1 and pd_active is 1.
- R5: Writing control bit 1 (force) with 1 enters power-down on the next cycle, regardless of the counter. Forced power-down ends in either of two ways:
  - Writing the bit with 0.
  - A strobe change, which also clears the bit; control bit 1 then reads back 0.
- R6: cs_park=1 drives mem_standby to 1 and leaves buf_en at 1 when no power-down is active.
- R7: The mask register (address 1) blocks strobes from the logic inputs: bit 0 for rd, bit 1 for wr, bit 2 for psen, bit 3 for ale.
  - A set bit holds the matching logic_* output at 0.
  - A clear bit passes the strobe, including during power-down.
- R8: Control bit 2 selects non-turbo logic mode (turbo_en = not bit 2). Control bit 3 drives zero_pwr_en.
- R9: Status register (address 3) reads bit 0 = power-down active, bit 1 = automatic cause, bit 2 = forced cause. Writes to it have no effect.
- R10: Clearing auto enable clears the idle count and ends automatic power-down on the next cycle.
- R11: While slow_clk_in does not toggle, the idle count holds and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_clk_in | input | 1 | Slow external clock for the idle counter, asynchronous |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_psen | input | 1 | Host program-fetch enable strobe |
| bus_ale | input | 1 | Host address latch enable strobe |
| cs_park | input | 1 | Chip-select park: puts the memories in standby |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| buf_en | output | 1 | Address/data input buffer enable |
| mem_standby | output | 1 | Memory standby request |
| pd_active | output | 1 | Power-down active |
| logic_rd | output | 1 | Read strobe to the logic inputs |
| logic_wr | output | 1 | Write strobe to the logic inputs |
| logic_psen | output | 1 | Program-fetch strobe to the logic inputs |
| logic_ale | output | 1 | Address latch strobe to the logic inputs |
| turbo_en | output | 1 | Logic turbo mode select |
| zero_pwr_en | output | 1 | Logic zero-power mode enable |

## Verification
The assertions check on every cycle these timing relations:
- the strobe-change wake-up,
- the forced entry,
- clearing by auto enable,
- the count holding while no slow edge arrives,
- a timeout only after the count met a nonzero limit,
- the mask gating,
- the chip-select park leaving the buffers on.

Only the bench scenarios can show the slow-clock path end to end. That covers the synchroniser latency, a timeout after a given number of slow edges and a zero limit never expiring. The scenarios also cover the register readback of causes, the self-clearing force bit and the ignored status writes.

// File: rtl/pd_pkg.sv
// pd_pkg: shared constants and types for the bus-activity power-down
// controller. Assumes an 8-bit register bus and four host strobes.
package pd_pkg;
    localparam int DATA_W = 8;
    localparam int STB_N  = 4;

    // Strobe bit positions (mask register bits use the same order)
    localparam int STB_RD   = 0;
    localparam int STB_WR   = 1;
    localparam int STB_PSEN = 2;
    localparam int STB_ALE  = 3;

    // Register addresses
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_MASK   = 2'd1;
    localparam logic [1:0] ADDR_LIMIT  = 2'd2;
    localparam logic [1:0] ADDR_STATUS = 2'd3;

    // Control register layout, bit 0 at the bottom
    typedef struct packed {
        logic zero_pwr;    // bit 3
        logic slow_logic;  // bit 2: non-turbo select
        logic force_pd;    // bit 1
        logic auto_en;     // bit 0
    } ctrl_t;
endpackage

// File: rtl/pd_activity_detect.sv
// pd_activity_detect: brings the asynchronous slow clock into the main
// clock domain through a synchroniser chain and flags its rising edges.
// It also flags any change on the host strobes.
// Assumes the strobes are already synchronous to clk.
module pd_activity_detect
    import pd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_clk_in,
    input  logic [STB_N-1:0] strobes,
    output logic             slow_rise,
    output logic             bus_act
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] sync_q;
    logic [STB_N-1:0]   stb_prev_q;

    // Shift the slow clock through the synchroniser plus one edge-detect stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[CHAIN_W-2:0], slow_clk_in};
        end
    end

    // Remember last strobe levels for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_prev_q <= '0;
        end else begin
            stb_prev_q <= strobes;
        end
    end

    // Edge and activity flags
    always_comb begin
        slow_rise = sync_q[CHAIN_W-2] & ~sync_q[CHAIN_W-1];
        bus_act   = |(strobes ^ stb_prev_q);
    end
endmodule

// File: rtl/pd_idle_timer.sv
// pd_idle_timer: counts synchronised slow-clock edges while the bus is quiet
// and raises automatic power-down once the count reaches the limit.
// The count saturates. A limit of zero never expires. Activity or a cleared
// enable restarts the count.
module pd_idle_timer #(
    parameter int LIM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             bus_act,
    input  logic             slow_rise,
    input  logic [LIM_W-1:0] limit,
    output logic [LIM_W-1:0] idle_cnt,
    output logic             auto_pd
);
    localparam logic [LIM_W-1:0] CNT_MAX = {LIM_W{1'b1}};

    logic restart;
    logic expired;

    // Restart and expiry conditions
    always_comb begin
        restart = !auto_en || bus_act;
        expired = (limit != '0) && (idle_cnt >= limit);
    end

    // Saturating idle-edge counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (restart) begin
            idle_cnt <= '0;
        end else if (slow_rise && idle_cnt != CNT_MAX) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // Sticky automatic power-down flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_pd <= 1'b0;
        end else if (restart) begin
            auto_pd <= 1'b0;
        end else if (expired) begin
            auto_pd <= 1'b1;
        end
    end
endmodule

// File: rtl/pd_reg_file.sv
// pd_reg_file: control, mask and limit registers plus the read-only status
// view. The force bit self-clears on bus activity unless a write to the
// control register lands in the same cycle.
// Assumes LIM_W <= DATA_W.
module pd_reg_file
    import pd_pkg::*;
#(
    parameter int LIM_W     = 4,
    parameter int DEF_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              bus_act,
    input  logic              auto_pd,
    output ctrl_t             ctrl,
    output logic [STB_N-1:0]  mask,
    output logic [LIM_W-1:0]  limit,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int USED_W = (LIM_W > 4) ? LIM_W : 4;

    logic wdata_unused;
    logic pd_any;

    assign wdata_unused = ^reg_wdata[DATA_W-1:USED_W];

    // Control register, with the force bit cleared by activity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (reg_we && reg_addr == ADDR_CTRL) begin
            ctrl <= ctrl_t'(reg_wdata[3:0]);
        end else if (bus_act) begin
            ctrl.force_pd <= 1'b0;
        end
    end

    // Strobe mask register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (reg_we && reg_addr == ADDR_MASK) begin
            mask <= reg_wdata[STB_N-1:0];
        end
    end

    // Idle limit register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit <= LIM_W'(DEF_LIMIT);
        end else if (reg_we && reg_addr == ADDR_LIMIT) begin
            limit <= reg_wdata[LIM_W-1:0];
        end
    end

    // Read multiplexer; status is computed, never stored
    always_comb begin
        pd_any = auto_pd | ctrl.force_pd;
        unique case (reg_addr)
            ADDR_CTRL:  reg_rdata = DATA_W'(ctrl);
            ADDR_MASK:  reg_rdata = DATA_W'(mask);
            ADDR_LIMIT: reg_rdata = DATA_W'(limit);
            default:    reg_rdata = DATA_W'({ctrl.force_pd, auto_pd, pd_any});
        endcase
    end
endmodule

// File: rtl/pd_output_gate.sv
// pd_output_gate: combines the power-down sources into the buffer and
// memory controls, and gates each host strobe onto the logic inputs
// through its mask bit. Strobes are not gated by power-down itself.
module pd_output_gate
    import pd_pkg::*;
(
    input  logic [STB_N-1:0] strobes,
    input  logic [STB_N-1:0] mask,
    input  logic             auto_pd,
    input  logic             force_pd,
    input  logic             cs_park,
    output logic [STB_N-1:0] logic_stb,
    output logic             buf_en,
    output logic             mem_standby,
    output logic             pd_active
);
    // Per-strobe gating onto the logic inputs
    for (genvar i = 0; i < STB_N; i++) begin : g_gate
        assign logic_stb[i] = strobes[i] & ~mask[i];
    end

    // Power-down reach: buffers for both power-down paths, memories also for park
    always_comb begin
        pd_active   = auto_pd | force_pd;
        buf_en      = ~pd_active;
        mem_standby = pd_active | cs_park;
    end
endmodule

// File: rtl/bus_idle_pwr_ctrl.sv
// bus_idle_pwr_ctrl: top of the bus-activity power-down controller.
// It ties together activity detection, the idle timer, the register file
// and the output gating. Assumes the strobes and register port are
// synchronous to clk, and slow_clk_in is asynchronous and much slower.
module bus_idle_pwr_ctrl
    import pd_pkg::*;
#(
    parameter int LIM_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DEF_LIMIT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk_in,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_psen,
    input  logic              bus_ale,
    input  logic              cs_park,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              buf_en,
    output logic              mem_standby,
    output logic              pd_active,
    output logic              logic_rd,
    output logic              logic_wr,
    output logic              logic_psen,
    output logic              logic_ale,
    output logic              turbo_en,
    output logic              zero_pwr_en
);
    logic [STB_N-1:0] strobes;
    logic [STB_N-1:0] logic_stb;
    logic [STB_N-1:0] mask;
    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] idle_cnt;
    logic             slow_rise;
    logic             bus_act;
    logic             auto_pd;
    ctrl_t            ctrl;

    // Pack the strobes in mask-bit order
    always_comb begin
        strobes[STB_RD]   = bus_rd;
        strobes[STB_WR]   = bus_wr;
        strobes[STB_PSEN] = bus_psen;
        strobes[STB_ALE]  = bus_ale;
    end

    pd_activity_detect #(.SYNC_STAGES(SYNC_STAGES)) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_clk_in(slow_clk_in),
        .strobes    (strobes),
        .slow_rise  (slow_rise),
        .bus_act    (bus_act)
    );

    pd_idle_timer #(.LIM_W(LIM_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (ctrl.auto_en),
        .bus_act  (bus_act),
        .slow_rise(slow_rise),
        .limit    (limit),
        .idle_cnt (idle_cnt),
        .auto_pd  (auto_pd)
    );

    pd_reg_file #(.LIM_W(LIM_W), .DEF_LIMIT(DEF_LIMIT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .bus_act  (bus_act),
        .auto_pd  (auto_pd),
        .ctrl     (ctrl),
        .mask     (mask),
        .limit    (limit),
        .reg_rdata(reg_rdata)
    );

    pd_output_gate u_gate (
        .strobes    (strobes),
        .mask       (mask),
        .auto_pd    (auto_pd),
        .force_pd   (ctrl.force_pd),
        .cs_park    (cs_park),
        .logic_stb  (logic_stb),
        .buf_en     (buf_en),
        .mem_standby(mem_standby),
        .pd_active  (pd_active)
    );

    // Unpack the gated strobes and the mode selects
    always_comb begin
        logic_rd    = logic_stb[STB_RD];
        logic_wr    = logic_stb[STB_WR];
        logic_psen  = logic_stb[STB_PSEN];
        logic_ale   = logic_stb[STB_ALE];
        turbo_en    = ~ctrl.slow_logic;
        zero_pwr_en = ctrl.zero_pwr;
    end
endmodule

// File: rtl/pd_ctrl_checker.sv
// pd_ctrl_checker: timing properties of the power-down controller, bound
// into every bus_idle_pwr_ctrl instance. Observes internal flags and ports.
module pd_ctrl_checker
    import pd_pkg::*;
#(
    parameter int LIM_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_act,
    input logic              slow_rise,
    input logic              auto_en,
    input logic              auto_pd,
    input logic              force_pd,
    input logic [LIM_W-1:0]  idle_cnt,
    input logic [LIM_W-1:0]  limit,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              buf_en,
    input logic              mem_standby,
    input logic              cs_park,
    input logic [STB_N-1:0]  mask,
    input logic [STB_N-1:0]  logic_stb
);
    logic force_wr;
    assign force_wr = reg_we && reg_addr == ADDR_CTRL && reg_wdata[1];

    assert_timeout_after_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auto_pd) |-> $past(limit != '0 && idle_cnt >= limit));

    assert_toggle_exits_auto_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_act |=> !auto_pd);

    assert_toggle_restores_buf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_act && !force_wr) |=> buf_en);

    assert_pd_parks_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_en |-> mem_standby);

    assert_force_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        force_wr |=> (force_pd && !buf_en));

    assert_park_keeps_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_park && !auto_pd && !force_pd) |-> (buf_en && mem_standby));

    assert_mask_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask & logic_stb) == '0);

    assert_auto_off_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> (idle_cnt == '0 && !auto_pd));

    assert_cnt_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !bus_act && !slow_rise) |=> $stable(idle_cnt));
endmodule

bind bus_idle_pwr_ctrl pd_ctrl_checker #(.LIM_W(LIM_W)) u_pd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_act    (bus_act),
    .slow_rise  (slow_rise),
    .auto_en    (ctrl.auto_en),
    .auto_pd    (auto_pd),
    .force_pd   (ctrl.force_pd),
    .idle_cnt   (idle_cnt),
    .limit      (limit),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .buf_en     (buf_en),
    .mem_standby(mem_standby),
    .cs_park    (cs_park),
    .mask       (mask),
    .logic_stb  (logic_stb)
);

// File: tb/bus_idle_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model updated on every rising edge is
// compared with all outputs in each cycle. Directed scenarios add checks
// tagged by requirement.
module bus_idle_pwr_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow = 1'b0;
    logic [3:0] stb = 4'h0;   // bit0 rd, bit1 wr, bit2 psen, bit3 ale
    logic       cs = 1'b0;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rdata;
    logic       buf_en, mem_standby, pd_active;
    logic       l_rd, l_wr, l_psen, l_ale, turbo_en, zp_en;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit slow_run = 1'b0;
    int sdiv = 0;

    always #5 clk = ~clk;

    bus_idle_pwr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .slow_clk_in(slow),
        .bus_rd(stb[0]), .bus_wr(stb[1]), .bus_psen(stb[2]), .bus_ale(stb[3]),
        .cs_park(cs), .reg_we(we), .reg_addr(addr), .reg_wdata(wd),
        .reg_rdata(rdata), .buf_en(buf_en), .mem_standby(mem_standby),
        .pd_active(pd_active), .logic_rd(l_rd), .logic_wr(l_wr),
        .logic_psen(l_psen), .logic_ale(l_ale), .turbo_en(turbo_en),
        .zero_pwr_en(zp_en)
    );

    // Reference model state
    bit       m_valid = 1'b0;
    bit       m_s1, m_s2, m_s3;
    bit [3:0] m_prev, m_mask, m_ctrl;
    int       m_cnt, m_lim;
    bit       m_apd;

    // Model: advance one cycle using the inputs present at this edge
    always @(posedge clk) begin
        bit act, rise;
        int n_cnt;
        bit n_apd;
        if (!rst_n) begin
            m_valid = 1'b1;
            {m_s1, m_s2, m_s3} = 3'b000;
            m_prev = 0; m_mask = 0; m_ctrl = 0;
            m_cnt = 0; m_lim = 8; m_apd = 0;
        end else begin
            act = (stb != m_prev);
            rise = m_s2 && !m_s3;
            n_cnt = m_cnt; n_apd = m_apd;
            if (!m_ctrl[0] || act) begin
                n_cnt = 0; n_apd = 0;
            end else begin
                if (rise && m_cnt < 15) n_cnt = m_cnt + 1;
                if (m_lim != 0 && m_cnt >= m_lim) n_apd = 1;
            end
            if (we && addr == 2'd0) m_ctrl = wd[3:0];
            else if (act) m_ctrl[1] = 1'b0;
            if (we && addr == 2'd1) m_mask = wd[3:0];
            if (we && addr == 2'd2) m_lim = int'(wd[3:0]);
            m_cnt = n_cnt; m_apd = n_apd;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = slow;
            m_prev = stb;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] m_rdata();
        bit pd = m_apd | m_ctrl[1];
        case (addr)
            2'd0: return {4'h0, m_ctrl};
            2'd1: return {4'h0, m_mask};
            2'd2: return 8'(m_lim);
            default: return {5'h0, m_ctrl[1], m_apd, pd};
        endcase
    endfunction

    // Per-cycle comparison with the reference model
    always begin
        @(negedge clk);
        #3;
        if (m_valid && !done) begin
            chk("R4", "buf_en", buf_en, !(m_apd | m_ctrl[1]));
            chk("R4", "pd_active", pd_active, m_apd | m_ctrl[1]);
            chk("R6", "mem_standby", mem_standby, m_apd | m_ctrl[1] | cs);
            chk("R7", "logic strobes", {l_ale, l_psen, l_wr, l_rd}, stb & ~m_mask);
            chk("R8", "turbo_en", turbo_en, !m_ctrl[2]);
            chk("R8", "zero_pwr_en", zp_en, m_ctrl[3]);
            chk("R9", "reg_rdata", rdata, m_rdata());
        end
    end

    // Slow clock generator: one half period is four main cycles
    always @(negedge clk) begin
        if (slow_run) begin
            sdiv++;
            if (sdiv == 4) begin
                sdiv = 0;
                slow = ~slow;
            end
        end
    end

    task automatic summary();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual %0d cycles expected < 100000", cyc);
            summary();
        end
    end

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wd = d;
        @(negedge clk);
        we = 1'b0; wd = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic toggle(input int i);
        @(negedge clk);
        stb[i] = ~stb[i];
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset state
        settle();
        chk("R1", "buf_en", buf_en, 1);
        chk("R1", "turbo_en", turbo_en, 1);
        chk("R1", "zero_pwr_en", zp_en, 0);
        rd(2'd0, v); chk("R1", "ctrl", v, 8'h00);
        rd(2'd2, v); chk("R1", "limit", v, 8'h08);
        rd(2'd3, v); chk("R1", "status", v, 8'h00);

        // R2, R4: automatic timeout with limit 3
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h01);
        slow_run = 1'b1;
        wait_cyc(60);
        settle();
        rd(2'd3, v); chk("R2", "status after timeout", v, 8'h03);
        chk("R4", "buf_en in power-down", buf_en, 0);
        chk("R4", "mem_standby in power-down", mem_standby, 1);

        // R3: strobe change wakes on the next cycle
        toggle(0);
        #2;
        chk("R3", "buf_en after rd change", buf_en, 1);
        rd(2'd3, v); chk("R3", "status after wake", v, 8'h00);
        wait_cyc(60);
        toggle(3);
        #2;
        chk("R3", "buf_en after ale change", buf_en, 1);

        // R11: stopped slow clock never times out
        slow_run = 1'b0;
        toggle(1);
        wait_cyc(100);
        settle();
        chk("R11", "buf_en with slow clock stopped", buf_en, 1);

        // R10: disabling auto mode stops the timer
        slow_run = 1'b1;
        wr(2'd0, 8'h00);
        wait_cyc(60);
        settle();
        chk("R10", "buf_en with auto disabled", buf_en, 1);

        // R2: limit 0 never expires
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h01);
        wait_cyc(80);
        settle();
        chk("R2", "buf_en with zero limit", buf_en, 1);

        // R5: forced power-down, write exit and strobe exit
        slow_run = 1'b0;
        wr(2'd0, 8'h02);
        #2;
        chk("R5", "buf_en forced", buf_en, 0);
        rd(2'd3, v); chk("R5", "status forced", v, 8'h05);
        wr(2'd0, 8'h00);
        #2;
        chk("R5", "buf_en after clearing force", buf_en, 1);
        wr(2'd0, 8'h02);
        toggle(2);
        #2;
        chk("R5", "buf_en after strobe exit", buf_en, 1);
        rd(2'd0, v); chk("R5", "force bit self-cleared", v, 8'h00);

        // R6: chip-select park parks memories only
        @(negedge clk);
        cs = 1'b1;
        #2;
        chk("R6", "mem_standby parked", mem_standby, 1);
        chk("R6", "buf_en parked", buf_en, 1);
        @(negedge clk);
        cs = 1'b0;

        // R7: per-strobe masking, also during power-down
        wr(2'd1, 8'h05);
        @(negedge clk);
        stb = 4'hF;
        #2;
        chk("R7", "logic_rd masked", l_rd, 0);
        chk("R7", "logic_wr passed", l_wr, 1);
        chk("R7", "logic_psen masked", l_psen, 0);
        chk("R7", "logic_ale passed", l_ale, 1);
        wr(2'd0, 8'h02);
        #2;
        chk("R7", "logic_wr passed in power-down", l_wr, 1);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);

        // R8: mode selects
        wr(2'd0, 8'h0C);
        #2;
        chk("R8", "turbo_en non-turbo", turbo_en, 0);
        chk("R8", "zero_pwr_en set", zp_en, 1);
        rd(2'd0, v); chk("R8", "ctrl readback", v, 8'h0C);

        // R9: status register ignores writes
        wr(2'd3, 8'hFF);
        #2;
        rd(2'd3, v); chk("R9", "status after write", v, 8'h00);
        chk("R9", "buf_en after status write", buf_en, 1);

        wait_cyc(2);
        summary();
    end
endmodule